// File: doc/BRIEF.md
# Pseudo-random test pattern checker for converter samples

This block watches a stream of 16-bit converter samples and confirms that the capture path delivers them intact. The converter is expected to send a pseudo-random bit sequence. One of two shift-register sequences is in use, picked by a select input. The lengths are 9 and 23 stages. Each sample carries 16 consecutive sequence bits. The earliest bit sits at the top of the word, and the top bit of every word is inverted before it is sent. A checker built for the plain sequence would therefore reject every word.

The checker first seeds its reference from the incoming words. After a run of matching words it declares lock and runs its reference on its own. From then on it counts every word that differs and keeps a sticky error flag. Eight misses in a row drop lock and start seeding again. A resync request or a change of the select clears everything. All outputs come straight from registers, and the integration logic is responsible for any crossing into a processor domain.

Top module: `pn_pattern_checker`

## Requirements
- R1: After a synchronous reset, the lock flag, the error flag and the error count are all zero.
- R2: Sequence bits follow b[n] = b[n-9] ^ b[n-5] when the select is 0, and b[n] = b[n-23] ^ b[n-18] when it is 1. Each valid sample carries the next 16 bits, with the earliest in bit 15. Bit 15 is then inverted, and bits 14:0 are sent as generated. A stream built this way locks and then raises no errors.
- R3: The plain sequence, without the inversion of bit 15, never produces lock.
- R4: Seeding first loads one word (select 0) or two words (select 1) without comparing them. Every later valid word is compared against the prediction. Lock rises at the clock edge that takes the 16th consecutive matching comparison, so lock comes after 17 or 18 clean words.
- R5: A mismatch during seeding restarts the run of matches from zero.
- R6: A cycle with the valid strobe low changes no output and no internal progress, whatever the sample value.
- R7: While locked, each mismatching valid word adds one to the error count and sets the error flag. The flag stays set through later matching words.
- R8: While locked, eight consecutive mismatches clear lock at the eighth one. Seeding then restarts from the word-loading step. Seven mismatches followed by a match keep lock. Neither case clears the count or the flag.
- R9: The error count is 16 bits wide and holds at 65535 instead of wrapping.
- R10: A resync request clears lock, the flag and the count at the next edge, and the sample in that cycle is ignored.
- R11: A change of the select value clears lock, the flag and the count in the same way as R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_i | input | 16 | Captured converter sample |
| smp_vld_i | input | 1 | Sample strobe |
| pn_sel_i | input | 1 | Sequence select: 0 short (9 stages), 1 long (23 stages) |
| resync_i | input | 1 | Request to clear status and seed again |
| lock_o | output | 1 | Reference locked to the stream |
| err_flag_o | output | 1 | Sticky error flag |
| err_cnt_o | output | 16 | Saturating count of mismatched words while locked |

## Verification
The bench attacks the exact lock boundary for both sequence lengths. A checker that compared the unseeded first word, or that counted one match too many or too few, would raise lock a cycle early or late. It feeds the plain sequence, which a checker lacking the top-bit inversion would lock onto. It also sends a corrupted word during seeding, which exposes a checker that does not restart its match run. It places seven and then eight misses in a row inside lock to pin down the drop threshold. It drives the count past 65535, where a wrapping counter would return to zero. It also sends garbage on idle cycles and on resync cycles, which catches a design that lets those words leak into its history.

// File: rtl/pn_chk_pkg.sv
package pn_chk_pkg;

  // index 0: short sequence, index 1: long sequence
  localparam int PN_KINDS = 2;

  function automatic int poly_len(input int kind);
    return (kind == 0) ? 9 : 23;
  endfunction

  function automatic int poly_tap(input int kind);
    return (kind == 0) ? 5 : 18;
  endfunction

  // words of history needed before a prediction is meaningful
  function automatic int words_for(input int len, input int dw);
    return (len + dw - 1) / dw;
  endfunction

endpackage

// File: rtl/pn_word_predict.sv
module pn_word_predict #(
  parameter int DATA_W = 16,
  parameter int HIST_W = 32,
  parameter int LEN    = 9,
  parameter int TAP    = 5
) (
  input  logic [HIST_W-1:0] hist_i,   // newest bit at [0]
  output logic [DATA_W-1:0] word_o    // next raw word, earliest bit at MSB
);

  localparam int EXT_W = HIST_W + DATA_W;

  always_comb begin
    logic [EXT_W-1:0] ext;
    ext = {hist_i, {DATA_W{1'b0}}};
    for (int p = DATA_W - 1; p >= 0; p--) begin
      ext[p] = ext[p+LEN] ^ ext[p+TAP];
    end
    word_o = ext[DATA_W-1:0];
  end

endmodule

// File: rtl/pn_sync_ctrl.sv
module pn_sync_ctrl #(
  parameter int LOCK_CNT = 16,
  parameter int DROP_CNT = 8,
  parameter int FILL_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              vld_i,
  input  logic              match_i,
  input  logic [FILL_W-1:0] need_i,
  output logic              lock_o,
  output logic              err_hit_o
);

  localparam int MCNT_W = $clog2(LOCK_CNT);
  localparam int MISS_W = $clog2(DROP_CNT);

  logic [FILL_W-1:0] fill_q;
  logic [MCNT_W-1:0] mcnt_q;
  logic [MISS_W-1:0] miss_q;
  logic              lock_q;
  logic              filled;

  assign filled    = (fill_q >= need_i);
  assign lock_o    = lock_q;
  assign err_hit_o = vld_i && lock_q && !match_i && !clr_i;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      fill_q <= '0;
      mcnt_q <= '0;
      miss_q <= '0;
      lock_q <= 1'b0;
    end else if (vld_i) begin
      if (!lock_q) begin
        if (!filled) begin
          fill_q <= fill_q + 1'b1;
        end else if (match_i) begin
          if (mcnt_q == MCNT_W'(LOCK_CNT - 1)) begin
            lock_q <= 1'b1;
            mcnt_q <= '0;
            miss_q <= '0;
          end else begin
            mcnt_q <= mcnt_q + 1'b1;
          end
        end else begin
          mcnt_q <= '0;
        end
      end else begin
        if (match_i) begin
          miss_q <= '0;
        end else if (miss_q == MISS_W'(DROP_CNT - 1)) begin
          lock_q <= 1'b0;
          fill_q <= '0;
          mcnt_q <= '0;
          miss_q <= '0;
        end else begin
          miss_q <= miss_q + 1'b1;
        end
      end
    end
  end

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    lock_o && !clr_i && !(vld_i && !match_i) |=> lock_o);

  // R4
  lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !lock_o && !(vld_i && match_i) |=> !lock_o);

endmodule

// File: rtl/pn_err_tally.sv
module pn_err_tally #(
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             hit_i,
  output logic [ERR_W-1:0] cnt_o,
  output logic             flag_o
);

  localparam logic [ERR_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_o  <= '0;
      flag_o <= 1'b0;
    end else if (hit_i) begin
      flag_o <= 1'b1;
      if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
    end
  end

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    flag_o && !clr_i |=> flag_o);

  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> (cnt_o == $past(cnt_o)) || (cnt_o == ERR_W'($past(cnt_o) + 1'b1)));

  // R9
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_o == CNT_MAX) && !clr_i |=> cnt_o == CNT_MAX);

endmodule

// File: rtl/pn_pattern_checker.sv
module pn_pattern_checker
  import pn_chk_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ERR_W    = 16,
  parameter int LOCK_CNT = 16,
  parameter int DROP_CNT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] smp_i,
  input  logic              smp_vld_i,
  input  logic              pn_sel_i,
  input  logic              resync_i,
  output logic              lock_o,
  output logic              err_flag_o,
  output logic [ERR_W-1:0]  err_cnt_o
);

  localparam int MAX_WORDS = words_for(poly_len(PN_KINDS - 1), DATA_W);
  localparam int HIST_W    = MAX_WORDS * DATA_W;
  localparam int FILL_W    = $clog2(MAX_WORDS + 1);
  localparam logic [DATA_W-1:0] TOP_MASK = DATA_W'(1) << (DATA_W - 1);

  logic              sel_q;
  logic              clr;
  logic [HIST_W-1:0] hist_q;
  logic [DATA_W-1:0] pred_raw [PN_KINDS];
  logic [DATA_W-1:0] pred_sel;
  logic [DATA_W-1:0] rx_raw;
  logic              match;
  logic              err_hit;
  logic [FILL_W-1:0] need;

  always_ff @(posedge clk) sel_q <= pn_sel_i;

  assign clr    = resync_i || (pn_sel_i != sel_q);
  assign rx_raw = smp_i ^ TOP_MASK;

  for (genvar g = 0; g < PN_KINDS; g++) begin : gen_poly
    pn_word_predict #(
      .DATA_W(DATA_W),
      .HIST_W(HIST_W),
      .LEN   (poly_len(g)),
      .TAP   (poly_tap(g))
    ) u_pred (
      .hist_i(hist_q),
      .word_o(pred_raw[g])
    );
  end

  assign pred_sel = pred_raw[pn_sel_i];
  assign match    = (rx_raw == pred_sel);
  assign need     = pn_sel_i ? FILL_W'(words_for(poly_len(1), DATA_W))
                             : FILL_W'(words_for(poly_len(0), DATA_W));

  // seeding shifts in received words; locked runs free on its own prediction
  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else if (smp_vld_i && !clr) begin
      hist_q <= {hist_q[HIST_W-DATA_W-1:0], (lock_o ? pred_sel : rx_raw)};
    end
  end

  pn_sync_ctrl #(
    .LOCK_CNT(LOCK_CNT),
    .DROP_CNT(DROP_CNT),
    .FILL_W  (FILL_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (clr),
    .vld_i    (smp_vld_i),
    .match_i  (match),
    .need_i   (need),
    .lock_o   (lock_o),
    .err_hit_o(err_hit)
  );

  pn_err_tally #(
    .ERR_W(ERR_W)
  ) u_tally (
    .clk   (clk),
    .rst   (rst),
    .clr_i (clr),
    .hit_i (err_hit),
    .cnt_o (err_cnt_o),
    .flag_o(err_flag_o)
  );

  // R10
  resync_clear_chk: assert property (@(posedge clk) disable iff (rst)
    resync_i |=> !lock_o && !err_flag_o && (err_cnt_o == '0));

  // R11
  sel_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (pn_sel_i != sel_q) |=> !lock_o && !err_flag_o && (err_cnt_o == '0));

endmodule

// File: tb/tb_pn_pattern_checker.sv
`timescale 1ns/1ps
module tb_pn_pattern_checker;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] smp = 16'h0;
  logic        vld = 1'b0;
  logic        sel = 1'b0;
  logic        rsy = 1'b0;
  logic        lock_o;
  logic        err_flag_o;
  logic [15:0] err_cnt_o;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  pn_pattern_checker dut (
    .clk       (clk),
    .rst       (rst),
    .smp_i     (smp),
    .smp_vld_i (vld),
    .pn_sel_i  (sel),
    .resync_i  (rsy),
    .lock_o    (lock_o),
    .err_flag_o(err_flag_o),
    .err_cnt_o (err_cnt_o)
  );

  typedef struct {
    logic        lock;
    logic        flag;
    logic [15:0] cnt;
    string       req;
  } exp_t;

  exp_t exp_q[$];

  // requirement model
  logic m_lock = 0, m_flag = 0, m_selq = 0;
  int   m_cnt = 0, m_fill = 0, m_mcnt = 0, m_miss = 0;
  logic cur_sel = 0;
  logic [22:0] gs = 23'h5A3C1F;

  task automatic check_val(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, expv, $time);
    end
  endtask

  task automatic gen(input logic plain, output logic [15:0] w);
    logic nb;
    for (int i = 0; i < 16; i++) begin
      nb = cur_sel ? (gs[22] ^ gs[17]) : (gs[8] ^ gs[4]);
      gs = {gs[21:0], nb};
      w  = {w[14:0], nb};
    end
    if (!plain) w = w ^ 16'h8000;
  endtask

  task automatic cyc(input logic v, input logic [15:0] d, input logic s,
                     input logic r, input logic m, input string req);
    exp_t e;
    int need;
    @(negedge clk);
    smp = d; vld = v; sel = s; rsy = r;
    need = s ? 2 : 1;
    if (r || (s != m_selq)) begin
      m_lock = 0; m_flag = 0; m_cnt = 0; m_fill = 0; m_mcnt = 0; m_miss = 0;
    end else if (v) begin
      if (!m_lock) begin
        if (m_fill < need) m_fill++;
        else if (m) begin
          m_mcnt++;
          if (m_mcnt == 16) begin m_lock = 1; m_mcnt = 0; m_miss = 0; end
        end else m_mcnt = 0;
      end else if (m) begin
        m_miss = 0;
      end else begin
        m_flag = 1;
        if (m_cnt < 65535) m_cnt++;
        m_miss++;
        if (m_miss == 8) begin m_lock = 0; m_fill = 0; m_mcnt = 0; m_miss = 0; end
      end
    end
    m_selq = s;
    e.lock = m_lock; e.flag = m_flag; e.cnt = 16'(m_cnt); e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic good(input int n, input string req);
    logic [15:0] w;
    for (int i = 0; i < n; i++) begin
      gen(1'b0, w);
      cyc(1'b1, w, cur_sel, 1'b0, 1'b1, req);
    end
  endtask

  task automatic bad(input int n, input string req);
    logic [15:0] w;
    for (int i = 0; i < n; i++) begin
      gen(1'b0, w);
      cyc(1'b1, w ^ 16'h0001, cur_sel, 1'b0, 1'b0, req);
    end
  endtask

  task automatic plain(input int n, input string req);
    logic [15:0] w;
    for (int i = 0; i < n; i++) begin
      gen(1'b1, w);
      cyc(1'b1, w, cur_sel, 1'b0, 1'b0, req);
    end
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) cyc(1'b0, 16'hBEEF ^ 16'(i), cur_sel, 1'b0, 1'b0, req);
  endtask

  // scoreboard monitor: compare a quarter period after the sampling edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        #5;
        check_val(e.req, "lock", int'(lock_o), int'(e.lock));
        check_val(e.req, "err_flag", int'(err_flag_o), int'(e.flag));
        check_val(e.req, "err_cnt", int'(err_cnt_o), int'(e.cnt));
      end
    end
  end

  initial begin
    #(20ns * 190000);
    failures++;
    $display("FAIL watchdog all actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] w;
    repeat (3) @(negedge clk);
    // R1: state under reset
    check_val("R1", "lock", int'(lock_o), 0);
    check_val("R1", "err_flag", int'(err_flag_o), 0);
    check_val("R1", "err_cnt", int'(err_cnt_o), 0);
    rst = 1'b0;

    // R4: short sequence locks on exactly the 17th clean word
    good(16, "R4_short_before");
    good(1, "R4_short_edge");
    // R6: idle cycles with junk data change nothing
    idle(4, "R6_locked_idle");
    // R2: sustained clean stream
    good(20, "R2_short_stream");

    // R7: one error, then sticky flag through matches
    bad(1, "R7_single");
    good(5, "R7_sticky");

    // R8: seven misses keep lock, eight drop it, counts survive
    bad(7, "R8_seven");
    good(1, "R8_recover");
    bad(8, "R8_eight");
    idle(2, "R6_unlocked_idle");
    good(17, "R8_reseed");

    // R10: resync with a junk valid sample in the same cycle
    cyc(1'b1, 16'h1234, cur_sel, 1'b1, 1'b0, "R10_resync");
    good(8, "R6_seed_part1");
    idle(3, "R6_seed_idle");
    good(9, "R10_relock");

    // R5: corruption during seeding restarts the match run
    cyc(1'b0, 16'h0, cur_sel, 1'b1, 1'b0, "R10_resync2");
    good(10, "R5_prefix");
    gen(1'b0, w);
    cyc(1'b1, w ^ 16'h0001, cur_sel, 1'b0, 1'b0, "R5_corrupt");
    gen(1'b0, w);
    cyc(1'b1, w, cur_sel, 1'b0, 1'b0, "R5_after");
    good(15, "R5_not_yet");
    good(1, "R5_lock");

    // R11: switch to the long sequence
    cur_sel = 1'b1;
    cyc(1'b0, 16'h0, cur_sel, 1'b0, 1'b0, "R11_select");
    good(17, "R4_long_before");
    good(1, "R4_long_edge");
    good(10, "R2_long_stream");
    bad(1, "R7_long");
    good(3, "R2_long_after");

    // R3: plain sequence never locks
    cur_sel = 1'b0;
    cyc(1'b0, 16'h0, cur_sel, 1'b0, 1'b0, "R11_back");
    plain(40, "R3_plain_short");
    cur_sel = 1'b1;
    cyc(1'b0, 16'h0, cur_sel, 1'b0, 1'b0, "R11_to_long");
    plain(40, "R3_plain_long");

    // R9: saturate the error count
    cur_sel = 1'b0;
    cyc(1'b0, 16'h0, cur_sel, 1'b0, 1'b0, "R11_sat_prep");
    good(17, "R9_lock");
    for (int k = 0; k < 9363; k++) begin
      bad(7, "R9_fill");
      good(1, "R9_fill");
    end
    bad(3, "R9_hold");
    good(2, "R9_hold");

    repeat (3) @(negedge clk);
    check_val("R9", "final_cnt", int'(err_cnt_o), 65535);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule